// File: doc/BRIEF.md
# Dual-Channel Phase-Offset Waveform Generator

This block plays one stored waveform out on two sample buses at once. A single table of 16-bit samples is read at two addresses in the same cycle: a running index for channel A, and that index plus a programmable phase offset for channel B. With a sine table and an offset of a quarter of the table, channel B carries the matching cosine. The block also makes the sample clock for an external two-channel converter. That clock runs at half the system clock rate, and the shared index steps once per converter clock period.

The sample stream is fixed-rate. It has no valid/ready handshake and no back-pressure. The converter clock itself serves as the strobe: both buses take new values only at the system edge where the converter clock falls. They are therefore settled for the whole low phase and stay stable through the rising edge at which the converter captures them. The offset input and the table-write port are plain control pins. The write port loads the table before or during playback. The table has one write port and two synchronous read ports, so that it can map onto block RAM.

Top module: `wavegen_dual`

## Requirements
- R1: `dac_clk` is low during reset and inverts on every system clock edge after reset is released, so its first high phase starts at the first edge after release.
- R2: `smp_a` and `smp_b` change only at a system edge where `dac_clk` goes from high to low. They never change while `dac_clk` is high.
- R3: Channel A plays the table entries in ascending index order, one entry per `dac_clk` period. The 10-bit index wraps from entry 1023 to entry 0 by plain overflow.
- R4: In the same period as channel A shows entry i, channel B shows entry (i + offset) mod 1024. Both entries come from reads made in the same clock cycle.
- R5: `phase_off` is captured only at an index step, so a pair never mixes two offsets. A value present at step k governs the pair driven at step k+2.
- R6: A write with `wr_en` high stores `wr_data` at `wr_addr` at that clock edge. A read of the same entry at the same edge returns the old contents, and later reads return the new contents.
- R7: Synchronous reset sets the index to 0, holds `dac_clk` low and zeroes both buses. It also loads the offset register from `phase_off`. Both buses stay zero until the second falling `dac_clk` edge after release, which drives entry 0 and entry (0 + offset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_off | input | 10 | Phase offset of channel B relative to channel A, in table entries |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 10 | Table write address |
| wr_data | input | 16 | Table write data |
| dac_clk | output | 1 | Converter sample clock, half the system rate |
| smp_a | output | 16 | Channel A sample |
| smp_b | output | 16 | Channel B sample |

## Verification
Each index step at a falling `dac_clk` edge drives the pair that was read at the previous step. An offset applied during a high phase therefore first shows in the pair visible three high phases later. A write shows on the next read of its entry, but not on a read made at the same edge. The scoreboard pushes each expected pair three periods ahead, using the offset current at push time and a bench copy of the table. It compares the pair at the falling clock edge inside each `dac_clk` high phase, and compares those values with the values seen in the preceding low phase to prove they held. Explicit checks cover the exact periods around the offset change, the write collision, the index wrap and the zero samples before the first valid pair.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  localparam int unsigned WG_ADDR_W = 10;
  localparam int unsigned WG_DATA_W = 16;
  localparam int unsigned WG_NCHAN  = 2;

  typedef enum logic {
    DPH_LOW  = 1'b0,
    DPH_HIGH = 1'b1
  } dac_phase_e;
endpackage

// File: rtl/wavegen_phase.sv
// Converter clock phase, shared read index and registered phase offset.
module wavegen_phase
  import wavegen_pkg::*;
#(
  parameter int unsigned ADDR_W = WG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] phase_in,
  output logic              dac_clk,
  output logic              adv,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  dac_phase_e        ph_q;
  logic [ADDR_W-1:0] idx_q;
  logic [ADDR_W-1:0] off_q;

  // The index and the offset step together on the edge that drops the converter clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= DPH_LOW;
      idx_q <= '0;
      off_q <= phase_in;
    end else begin
      ph_q <= (ph_q == DPH_HIGH) ? DPH_LOW : DPH_HIGH;
      if (ph_q == DPH_HIGH) begin
        idx_q <= idx_q + STEP;
        off_q <= phase_in;
      end
    end
  end

  assign adv     = (ph_q == DPH_HIGH);
  assign dac_clk = (ph_q == DPH_HIGH);
  assign addr_a  = idx_q;
  assign addr_b  = idx_q + off_q;  // modulo 2**ADDR_W by width

  assert_dac_rise_R1: assert property (@(posedge clk) disable iff (rst)
    !dac_clk |=> dac_clk);
  assert_dac_fall_R1: assert property (@(posedge clk) disable iff (rst)
    dac_clk |=> !dac_clk);
  assert_index_step_R3: assert property (@(posedge clk) disable iff (rst)
    adv |=> addr_a == $past(addr_a) + STEP);
  assert_index_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(addr_a));
  assert_offset_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(addr_b));
endmodule

// File: rtl/wavegen_table.sv
// One write port, NRD synchronous read ports sharing one storage array.
module wavegen_table
  import wavegen_pkg::*;
#(
  parameter int unsigned ADDR_W = WG_ADDR_W,
  parameter int unsigned DATA_W = WG_DATA_W,
  parameter int unsigned NRD    = WG_NCHAN
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [NRD-1:0][ADDR_W-1:0] rd_addr,
  output logic [NRD-1:0][DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  // Non-blocking reads see the contents from before a write at the same edge.
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (rd_en) q <= mem_q[rd_addr[g]];
    end
    assign rd_data[g] = q;
  end

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/wavegen_dual.sv
// Top: two phase-offset channels played from one shared table.
module wavegen_dual
  import wavegen_pkg::*;
#(
  parameter int unsigned ADDR_W = WG_ADDR_W,
  parameter int unsigned DATA_W = WG_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] phase_off,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dac_clk,
  output logic [DATA_W-1:0] smp_a,
  output logic [DATA_W-1:0] smp_b
);
  localparam int unsigned NCH = WG_NCHAN;

  logic                       adv;
  logic [ADDR_W-1:0]          addr_a;
  logic [ADDR_W-1:0]          addr_b;
  logic [NCH-1:0][DATA_W-1:0] rd_data;
  logic [NCH-1:0][DATA_W-1:0] smp_q;

  wavegen_phase #(.ADDR_W(ADDR_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .phase_in (phase_off),
    .dac_clk  (dac_clk),
    .adv      (adv),
    .addr_a   (addr_a),
    .addr_b   (addr_b)
  );

  wavegen_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NCH)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (adv),
    .rd_addr ({addr_b, addr_a}),
    .rd_data (rd_data)
  );

  // Output stage: loads only when the converter clock falls.
  for (genvar c = 0; c < NCH; c++) begin : g_out
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)      q <= '0;
      else if (adv) q <= rd_data[c];
    end
    assign smp_q[c] = q;
  end

  assign smp_a = smp_q[0];
  assign smp_b = smp_q[1];

  assert_hold_high_R2: assert property (@(posedge clk) disable iff (rst)
    dac_clk |-> ($stable(smp_a) && $stable(smp_b)));
  assert_change_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !($stable(smp_a) && $stable(smp_b)) |-> ($past(dac_clk) && !dac_clk));
  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> (!dac_clk && smp_a == '0 && smp_b == '0));
endmodule

// File: tb/wavegen_dual_bench.sv
module wavegen_dual_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;
  localparam int NPER       = 2300;
  localparam int INIT_OFF   = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  phase_off;
  logic        wr_en;
  logic [9:0]  wr_addr;
  logic [15:0] wr_data;
  logic        dac_clk;
  logic [15:0] smp_a;
  logic [15:0] smp_b;

  wavegen_dual u_wavegen_dual (
    .clk(clk), .rst(rst), .phase_off(phase_off), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dac_clk(dac_clk),
    .smp_a(smp_a), .smp_b(smp_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          h;
    int          ia;
    int          ib;
    logic [15:0] a;
    logic [15:0] b;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] model [DEPTH];
  int          n_checks = 0;
  int          n_fail   = 0;
  int          cur_off;
  logic [15:0] low_a, low_b;

  function automatic logic [15:0] ramp(int i);
    return {6'b101101, 10'(i)};
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Driver side: expected pair for high phase h, using the offset applied now.
  task automatic drive_push(int h);
    exp_t e;
    e.h = h;
    if (h < 2) begin
      e.ia = -1; e.ib = -1; e.a = '0; e.b = '0;
    end else begin
      e.ia = (h - 2) % DEPTH;
      e.ib = (e.ia + cur_off) % DEPTH;
      e.a  = model[e.ia];
      e.b  = model[e.ib];
    end
    exp_q.push_back(e);
  endtask

  // Monitor side: compare the pair held during high phase h.
  task automatic monitor_pop(int h);
    exp_t e;
    if (exp_q.size() == 0) begin
      n_checks++; n_fail++;
      $display("FAIL R3 period %0d: actual no entry expected one queued", h);
      return;
    end
    e = exp_q.pop_front();
    if (e.ia < 0) begin
      check("R7", $sformatf("zero A before first pair, period %0d", h), smp_a, 16'h0);
      check("R7", $sformatf("zero B before first pair, period %0d", h), smp_b, 16'h0);
    end else begin
      check("R3", $sformatf("chan A period %0d entry %0d", h, e.ia), smp_a, e.a);
      check("R4", $sformatf("chan B period %0d entry %0d", h, e.ib), smp_b, e.b);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    phase_off = 10'(INIT_OFF);
    cur_off   = INIT_OFF;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    check("R7", "dac_clk in reset", {15'b0, dac_clk}, 16'h0);
    check("R7", "smp_a in reset", smp_a, 16'h0);
    check("R7", "smp_b in reset", smp_b, 16'h0);

    // R6: table loaded through the write port while held in reset
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_addr = 10'(i); wr_data = ramp(i); model[i] = ramp(i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R7", "dac_clk still low after load", {15'b0, dac_clk}, 16'h0);

    drive_push(0);
    drive_push(1);
    drive_push(2);
    rst = 1'b0;
    @(negedge clk);  // first high phase (R1)

    for (int h = 0; h < NPER; h++) begin
      check("R1", $sformatf("dac_clk high, period %0d", h), {15'b0, dac_clk}, 16'h1);
      if (h > 0) begin
        check("R2", $sformatf("A held into high phase %0d", h), smp_a, low_a);
        check("R2", $sformatf("B held into high phase %0d", h), smp_b, low_b);
      end
      monitor_pop(h);

      // Explicit corner checks
      if (h == 302)
        check("R5", "old offset still in use", {6'b0, 10'(smp_b[9:0] - smp_a[9:0])}, 16'd256);
      if (h == 303)
        check("R5", "new offset first used", {6'b0, 10'(smp_b[9:0] - smp_a[9:0])}, 16'd100);
      if (h == 502) check("R6", "same-edge read returns old data", smp_a, ramp(500));
      if (h == 852) check("R6", "written entry read back", smp_a, 16'hBEEF);
      if (h == 1025) check("R3", "entry 1023 before wrap", smp_a, ramp(1023));
      if (h == 1026) check("R3", "entry 0 after wrap", smp_a, ramp(0));
      if (h == 1526) check("R6", "collided write visible after wrap", smp_a, 16'h1234);

      // Offset schedule (R5, R4 with B address wrap)
      case (h)
        300:  cur_off = 100;
        700:  cur_off = 1000;
        900:  cur_off = 0;
        1200: cur_off = 256;
        default: ;
      endcase
      phase_off = 10'(cur_off);

      // Writes during playback (R6)
      if (h == 500) begin
        wr_en = 1'b1; wr_addr = 10'(500); wr_data = 16'h1234; model[500] = 16'h1234;
      end
      if (h == 800) begin
        wr_en = 1'b1; wr_addr = 10'(850); wr_data = 16'hBEEF; model[850] = 16'hBEEF;
      end

      drive_push(h + 3);

      @(negedge clk);  // low phase
      wr_en = 1'b0;
      check("R1", $sformatf("dac_clk low, period %0d", h), {15'b0, dac_clk}, 16'h0);
      low_a = smp_a;
      low_b = smp_b;
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule